// File: doc/BRIEF.md
# Reset Cause Status Register

This block holds a 16-bit status word that tells software why the device last came out of reset and whether it last entered a low-power state. Each cause has its own single-cycle event input. When an event arrives, the flag for that cause becomes 1 and stays 1. Flags never clear themselves. Software reads the word on `flags_o` and can overwrite every implemented flag with `wr_en`/`wr_data`. The usual practice is to clear the word after reading it, so that the next reset leaves a clean record.

Each flag has its own rules for what sets it and what clears it. The synchronous active-high `rst` input is the power-on event and has the highest priority of all. The brown-out event clears most of the reset-cause flags, but it leaves the power-on flag and the external-pin flag alone. Three separate causes share one flag: an illegal opcode, a use of an uninitialized register, and a protected-segment violation.

Top module: `rcause_reg`

## Requirements
- R1: In the cycle after `rst` is high, `flags_o` reads 16'h0003: the power-on flag (bit 0) and the brown-out flag (bit 1) are set, and every other bit is clear. This holds whatever the other inputs are doing.
- R2: Each event, when there is no write and no reset in the same cycle, sets its flag in the next cycle:
  - trap conflict sets bit 15
  - configuration mismatch sets bit 9
  - external pin reset sets bit 7
  - software reset sets bit 6
  - watchdog timeout sets bit 4
  - sleep entry sets bit 3
  - idle entry sets bit 2
- R3: Bit 14 is set by any one of three events: illegal opcode, uninitialized register use, or security violation.
- R4: A brown-out event with no write sets bit 1 and clears bits 15, 14, 9, 6, 4, 3 and 2. It leaves bits 0 and 7 unchanged.
- R5: A write loads the implemented bits of `wr_data` in the next cycle. The write takes priority over any event in the same cycle, brown-out included, but never over `rst`.
- R6: Bits 13, 12, 11, 10, 8 and 5 always read 0 and ignore writes.
- R7: With no event, no write and no reset, `flags_o` holds its value.
- R8: If an event arrives in the same cycle as a brown-out, its flag ends up set, even when brown-out would otherwise clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on event, active high |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 16 | Software write value |
| bor_evt | input | 1 | Brown-out event pulse |
| trap_evt | input | 1 | Trap conflict event pulse |
| illop_evt | input | 1 | Illegal opcode event pulse |
| uninit_evt | input | 1 | Uninitialized register use pulse |
| secur_evt | input | 1 | Protected-segment violation pulse |
| cfgmis_evt | input | 1 | Configuration mismatch event pulse |
| pin_evt | input | 1 | External reset pin event pulse |
| swrst_evt | input | 1 | Software reset instruction pulse |
| wdt_evt | input | 1 | Watchdog timeout pulse |
| sleep_evt | input | 1 | Sleep entry pulse |
| idle_evt | input | 1 | Idle entry pulse |
| flags_o | output | 16 | Registered status word |

## Verification
The assertions check the following on every cycle:
- the value left by reset
- that write data is loaded and wins over events
- that unused positions stay zero
- that brown-out sets its flag and keeps the pin flag
- that a trap event sets its flag
- that the word holds when nothing happens

Some behaviour only the bench scenarios can show. These are:
- that all three bit-14 causes set the shared flag
- that an event colliding with a brown-out wins
- the full mix of causes over long random runs checked against a bench model

// File: rtl/rcause_pkg.sv
package rcause_pkg;
  localparam int REG_W = 16;

  localparam int B_TRAP   = 15;
  localparam int B_ILL    = 14;
  localparam int B_CFGMIS = 9;
  localparam int B_PIN    = 7;
  localparam int B_SWRST  = 6;
  localparam int B_WDT    = 4;
  localparam int B_SLEEP  = 3;
  localparam int B_IDLE   = 2;
  localparam int B_BOR    = 1;
  localparam int B_POR    = 0;

  // positions that hold a flop
  localparam logic [REG_W-1:0] IMPL_MASK =
    (REG_W'(1) << B_TRAP) | (REG_W'(1) << B_ILL) | (REG_W'(1) << B_CFGMIS) |
    (REG_W'(1) << B_PIN) | (REG_W'(1) << B_SWRST) | (REG_W'(1) << B_WDT) |
    (REG_W'(1) << B_SLEEP) | (REG_W'(1) << B_IDLE) | (REG_W'(1) << B_BOR) |
    (REG_W'(1) << B_POR);

  // flags wiped by a brown-out
  localparam logic [REG_W-1:0] BOR_CLR_MASK =
    (REG_W'(1) << B_TRAP) | (REG_W'(1) << B_ILL) | (REG_W'(1) << B_CFGMIS) |
    (REG_W'(1) << B_SWRST) | (REG_W'(1) << B_WDT) | (REG_W'(1) << B_SLEEP) |
    (REG_W'(1) << B_IDLE);

  // value after a power-on
  localparam logic [REG_W-1:0] POR_VAL = (REG_W'(1) << B_BOR) | (REG_W'(1) << B_POR);

  typedef struct packed {
    logic trap;
    logic illop;
    logic uninit;
    logic secur;
    logic cfgmis;
    logic pin;
    logic swrst;
    logic wdt;
    logic sleep;
    logic idle;
    logic bor;
  } rc_evt_t;
endpackage

// File: rtl/rcause_event_map.sv
module rcause_event_map
  import rcause_pkg::*;
(
  input  rc_evt_t          evt,
  output logic [REG_W-1:0] set_vec
);
  always_comb begin
    set_vec           = '0;
    set_vec[B_TRAP]   = evt.trap;
    set_vec[B_ILL]    = evt.illop | evt.uninit | evt.secur;
    set_vec[B_CFGMIS] = evt.cfgmis;
    set_vec[B_PIN]    = evt.pin;
    set_vec[B_SWRST]  = evt.swrst;
    set_vec[B_WDT]    = evt.wdt;
    set_vec[B_SLEEP]  = evt.sleep;
    set_vec[B_IDLE]   = evt.idle;
    set_vec[B_BOR]    = evt.bor;
  end
endmodule

// File: rtl/rcause_flag_cell.sv
module rcause_flag_cell #(
  parameter bit IMPL    = 1'b1,
  parameter bit CLR_BOR = 1'b0,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic set_evt,
  input  logic bor_evt,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!IMPL)                   q <= 1'b0;
    else if (rst)                q <= RST_VAL;
    else if (wr_en)              q <= wr_bit;
    else if (set_evt)            q <= 1'b1;
    else if (bor_evt && CLR_BOR) q <= 1'b0;
  end

  // the write beats a same-cycle set or clear
  p_cell_write_r5: assert property (@(posedge clk) disable iff (rst)
    (IMPL && wr_en) |=> (q == $past(wr_bit)));
endmodule

// File: rtl/rcause_reg.sv
module rcause_reg
  import rcause_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             bor_evt,
  input  logic             trap_evt,
  input  logic             illop_evt,
  input  logic             uninit_evt,
  input  logic             secur_evt,
  input  logic             cfgmis_evt,
  input  logic             pin_evt,
  input  logic             swrst_evt,
  input  logic             wdt_evt,
  input  logic             sleep_evt,
  input  logic             idle_evt,
  output logic [REG_W-1:0] flags_o
);
  rc_evt_t          evt;
  logic [REG_W-1:0] set_vec;

  assign evt = '{trap: trap_evt, illop: illop_evt, uninit: uninit_evt,
                 secur: secur_evt, cfgmis: cfgmis_evt, pin: pin_evt,
                 swrst: swrst_evt, wdt: wdt_evt, sleep: sleep_evt,
                 idle: idle_evt, bor: bor_evt};

  rcause_event_map u_map (.evt(evt), .set_vec(set_vec));

  for (genvar i = 0; i < REG_W; i++) begin : g_flag
    rcause_flag_cell #(
      .IMPL   (IMPL_MASK[i]),
      .CLR_BOR(BOR_CLR_MASK[i]),
      .RST_VAL(POR_VAL[i])
    ) u_cell (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en),
      .wr_bit (wr_data[i]),
      .set_evt(set_vec[i]),
      .bor_evt(bor_evt),
      .q      (flags_o[i])
    );
  end

  logic any_evt;
  assign any_evt = |{trap_evt, illop_evt, uninit_evt, secur_evt, cfgmis_evt,
                     pin_evt, swrst_evt, wdt_evt, sleep_evt, idle_evt, bor_evt};

  p_por_value_r1: assert property (@(posedge clk)
    rst |=> (flags_o == POR_VAL));
  p_write_load_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (flags_o == ($past(wr_data) & IMPL_MASK)));
  p_unused_zero_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((flags_o & ~IMPL_MASK) == '0));
  p_trap_set_r2: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && trap_evt) |=> flags_o[B_TRAP]);
  p_bor_set_r4: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && bor_evt) |=> flags_o[B_BOR]);
  p_bor_keeps_pin_r4: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && bor_evt && !pin_evt) |=> (flags_o[B_PIN] == $past(flags_o[B_PIN])));
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !any_evt) |=> $stable(flags_o));
endmodule

// File: tb/test_rcause_reg.sv
`timescale 1ns/1ps
module test_rcause_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic bor_evt = 0, trap_evt = 0, illop_evt = 0, uninit_evt = 0, secur_evt = 0;
  logic cfgmis_evt = 0, pin_evt = 0, swrst_evt = 0, wdt_evt = 0, sleep_evt = 0, idle_evt = 0;
  logic [15:0] flags_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q = 16'h0003;

  always #2.5 clk = ~clk;

  rcause_reg i_rcause_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .bor_evt(bor_evt),
    .trap_evt(trap_evt), .illop_evt(illop_evt), .uninit_evt(uninit_evt),
    .secur_evt(secur_evt), .cfgmis_evt(cfgmis_evt), .pin_evt(pin_evt),
    .swrst_evt(swrst_evt), .wdt_evt(wdt_evt), .sleep_evt(sleep_evt),
    .idle_evt(idle_evt), .flags_o(flags_o));

  localparam logic [15:0] IMPL = 16'hC2DF;
  localparam logic [15:0] BCLR = 16'hC25C;

  function automatic logic [15:0] set_of();
    logic [15:0] s = '0;
    s[15] = trap_evt; s[14] = illop_evt | uninit_evt | secur_evt;
    s[9] = cfgmis_evt; s[7] = pin_evt; s[6] = swrst_evt; s[4] = wdt_evt;
    s[3] = sleep_evt; s[2] = idle_evt; s[1] = bor_evt;
    return s;
  endfunction

  function automatic logic [15:0] next_of(logic [15:0] cur);
    if (rst)   return 16'h0003;
    if (wr_en) return wr_data & IMPL;
    return (bor_evt ? (cur & ~BCLR) : cur) | set_of();
  endfunction

  task automatic clear_in();
    rst = 0; wr_en = 0; wr_data = '0; bor_evt = 0; trap_evt = 0; illop_evt = 0;
    uninit_evt = 0; secur_evt = 0; cfgmis_evt = 0; pin_evt = 0; swrst_evt = 0;
    wdt_evt = 0; sleep_evt = 0; idle_evt = 0;
  endtask

  // inputs are set after a negedge; this applies one posedge and checks at the next negedge
  task automatic step(string tag);
    exp_q = next_of(exp_q);
    @(negedge clk);
    checks++;
    if (flags_o !== exp_q) begin
      fails++;
      $display("FAIL %s: flags_o=%h expected=%h", tag, flags_o, exp_q);
    end
    clear_in();
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run hung, flags_o=%h expected=%h", flags_o, exp_q);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    rst = 1; step("R1 reset value");
    // R2: each single event
    trap_evt = 1;   step("R2 trap");
    cfgmis_evt = 1; step("R2 cfg mismatch");
    pin_evt = 1;    step("R2 pin");
    swrst_evt = 1;  step("R2 sw reset");
    wdt_evt = 1;    step("R2 watchdog");
    sleep_evt = 1;  step("R2 sleep");
    idle_evt = 1;   step("R2 idle");
    // R4: brown-out clears most, keeps bits 0 and 7
    bor_evt = 1;    step("R4 brown-out");
    // R3: the three sources of bit 14
    illop_evt = 1;  step("R3 illegal opcode");
    wr_en = 1;      step("R5 clear all");
    uninit_evt = 1; step("R3 uninit reg");
    wr_en = 1;      step("R5 clear all");
    secur_evt = 1;  step("R3 security");
    // R6: unused positions ignore writes
    wr_en = 1; wr_data = 16'hFFFF; step("R6 write ones");
    wr_en = 1; wr_data = 16'h3D20; step("R6 unused only");
    // R5: write beats same-cycle events, brown-out included
    wr_en = 1; wr_data = 16'h0000; trap_evt = 1; bor_evt = 1; step("R5 write priority");
    // R8: event with brown-out ends set
    wr_en = 1; wr_data = 16'h00DC; step("R5 preload");
    bor_evt = 1; wdt_evt = 1; sleep_evt = 1; step("R8 event with brown-out");
    // R7: hold
    step("R7 hold");
    // R1: reset beats a write
    rst = 1; wr_en = 1; wr_data = 16'hFFFF; trap_evt = 1; step("R1 reset priority");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      string tag;
      rst        = ($urandom_range(0, 99) == 0);
      wr_en      = ($urandom_range(0, 9) == 0);
      wr_data    = 16'($urandom);
      bor_evt    = ($urandom_range(0, 11) == 0);
      trap_evt   = ($urandom_range(0, 9) == 0);
      illop_evt  = ($urandom_range(0, 19) == 0);
      uninit_evt = ($urandom_range(0, 19) == 0);
      secur_evt  = ($urandom_range(0, 19) == 0);
      cfgmis_evt = ($urandom_range(0, 9) == 0);
      pin_evt    = ($urandom_range(0, 9) == 0);
      swrst_evt  = ($urandom_range(0, 9) == 0);
      wdt_evt    = ($urandom_range(0, 9) == 0);
      sleep_evt  = ($urandom_range(0, 9) == 0);
      idle_evt   = ($urandom_range(0, 9) == 0);
      if (rst) tag = "R1 random";
      else if (wr_en) tag = "R5 random";
      else if (bor_evt) tag = "R4 random";
      else if (set_of() != 0) tag = "R2 random";
      else tag = "R7 random";
      step(tag);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule